// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block orders the start-up of a switching power controller. A digital flag tells it that the supply has crossed its turn-on threshold. On that edge it enables a short precharge current source, raises a "soft-start active" flag, and enables a sink current whose strength is given as an unsigned binary code for an external DAC. The code starts at its highest value and drops by one at fixed intervals, so the regulated voltage climbs in steps. When the code reaches zero the sink and the active flag are switched off. A separate flag arms the burst comparator once the precharge pulse ends, and it stays set while the supply flag holds.

All intervals are counted in clock cycles and set by parameters. This lets silicon use real durations and simulation use short ones. Dropping the supply flag aborts the sequence at any point. Raising it again runs the whole sequence from the beginning.

Top module: `softstart_seq`

## Requirements
- R1: After reset, and while supply_en_i stays low, every output is low and sink_code_o is 0.
- R2: On the first rising clock edge that samples supply_en_i high while idle, the outputs become precharge_en_o=1, sink_en_o=1, ss_active_o=1, burst_arm_o=0, and sink_code_o=START_CODE (unsigned binary, default 8).
- R3: precharge_en_o stays high for exactly PRECHARGE_CYC cycles after the start edge, then stays low until the next start.
- R4: burst_arm_o rises in the same cycle that precharge_en_o falls, and stays high while supply_en_i stays high.
- R5: sink_code_o decreases by exactly one every STEP_CYC cycles after the start edge. It never changes by any other amount during the ramp.
- R6: START_CODE*STEP_CYC cycles after the start edge, sink_code_o is 0 and sink_en_o and ss_active_o are low. They remain so while supply_en_i stays high, so no new sequence starts.
- R7: A clock edge that samples supply_en_i low returns every output, burst_arm_o included, to its idle value, whatever the point in the sequence.
- R8: Raising supply_en_i again after a drop restarts the full sequence from the R2 state, whether the drop happened during precharge, during the ramp or after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_en_i | input | 1 | Supply above turn-on threshold, synchronous to clk_i |
| precharge_en_o | output | 1 | Precharge current source enable |
| sink_code_o | output | CODE_W | Sink current code for the DAC, unsigned binary |
| sink_en_o | output | 1 | Sink current enable |
| ss_active_o | output | 1 | Soft start in progress |
| burst_arm_o | output | 1 | Burst comparator armed |

## Verification
The assertions assume that supply_en_i is already synchronous to clk_i. They also assume that PRECHARGE_CYC is shorter than the full ramp, so that the hold state always has the burst comparator armed. The stimulus changes supply_en_i only on the falling clock edge. It uses a precharge of 5 cycles against a 96-cycle ramp. It drops the flag once during precharge, once mid-ramp and once after completion, and it also applies a single-cycle low pulse. A behavioural model built on elapsed-cycle counts is compared against every output on every clock.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RAMP = 2'd1,
    PH_HOLD = 2'd2
  } ss_phase_e;
endpackage

// File: rtl/ss_interval_timer.sv
module ss_interval_timer #(
  parameter int LIMIT   = 4,
  parameter bit ONESHOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  generate
    if (ONESHOT) begin : g_oneshot
      // saturates at LAST; owner drops run_i after the tick
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     cnt_q <= '0;
        else if (clr_i)                  cnt_q <= '0;
        else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_periodic
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (run_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ss_code_ctr.sv
module ss_code_ctr #(
  parameter int CODE_W     = 4,
  parameter int START_CODE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              dec_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o
);
  localparam logic [CODE_W-1:0] START = CODE_W'(START_CODE);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   code_q <= '0;
    else if (clr_i)                code_q <= '0;
    else if (load_i)               code_q <= START;
    else if (dec_i && code_q != 0) code_q <= code_q - 1'b1;
  end

  assign code_o = code_q;
  assign last_o = (code_q == CODE_W'(1));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int PRECHARGE_CYC = 1200,
  parameter int STEP_CYC      = 300000,
  parameter int START_CODE    = 8,
  parameter int CODE_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_en_i,
  output logic              precharge_en_o,
  output logic [CODE_W-1:0] sink_code_o,
  output logic              sink_en_o,
  output logic              ss_active_o,
  output logic              burst_arm_o
);
  ss_phase_e phase_q;
  logic      prech_q, burst_q;
  logic      start, tmr_clr, pre_tick, step_tick, code_last;

  assign start   = supply_en_i && (phase_q == PH_IDLE);
  assign tmr_clr = !supply_en_i || start;

  ss_interval_timer #(.LIMIT(PRECHARGE_CYC), .ONESHOT(1'b1)) u_pre_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr),
    .run_i (prech_q), .tick_o(pre_tick)
  );

  ss_interval_timer #(.LIMIT(STEP_CYC), .ONESHOT(1'b0)) u_step_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr),
    .run_i (phase_q == PH_RAMP), .tick_o(step_tick)
  );

  ss_code_ctr #(.CODE_W(CODE_W), .START_CODE(START_CODE)) u_code (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(!supply_en_i),
    .load_i(start), .dec_i(step_tick),
    .code_o(sink_code_o), .last_o(code_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= PH_IDLE;
    else if (!supply_en_i)      phase_q <= PH_IDLE;
    else begin
      unique case (phase_q)
        PH_IDLE: phase_q <= PH_RAMP;
        PH_RAMP: if (step_tick && code_last) phase_q <= PH_HOLD;
        default: phase_q <= PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prech_q <= 1'b0;
      burst_q <= 1'b0;
    end else if (!supply_en_i || start) begin
      prech_q <= start;
      burst_q <= 1'b0;
    end else if (pre_tick) begin
      prech_q <= 1'b0;
      burst_q <= 1'b1;
    end
  end

  assign precharge_en_o = prech_q;
  assign burst_arm_o    = burst_q;
  assign ss_active_o    = (phase_q == PH_RAMP);
  assign sink_en_o      = (phase_q == PH_RAMP);

  assert_start_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_active_o) |-> (precharge_en_o && !burst_arm_o
                            && sink_code_o == CODE_W'(START_CODE)));

  assert_arm_follows_precharge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(precharge_en_o) && $past(supply_en_i)) |-> burst_arm_o);

  assert_arm_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_arm_o && supply_en_i) |=> burst_arm_o);

  assert_step_by_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_o && supply_en_i) |=>
      (sink_code_o == $past(sink_code_o) || sink_code_o == $past(sink_code_o) - CODE_W'(1)));

  assert_sink_off_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sink_en_o |-> (sink_code_o == '0));

  assert_no_restart_in_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_active_o && burst_arm_o && supply_en_i) |=> !ss_active_o);

  assert_idle_after_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_en_i |=> (!precharge_en_o && !sink_en_o && !ss_active_o
                      && !burst_arm_o && sink_code_o == '0));
endmodule

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
  localparam int P = 5;
  localparam int S = 12;
  localparam int N = 8;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic prech, sink_en, active, arm;
  logic [W-1:0] code;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model: running flag and edges since start
  bit m_run = 1'b0;
  int m_k = 0;

  always #2.5 clk = ~clk;

  softstart_seq #(.PRECHARGE_CYC(P), .STEP_CYC(S), .START_CODE(N), .CODE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .supply_en_i(en),
    .precharge_en_o(prech), .sink_code_o(code), .sink_en_o(sink_en),
    .ss_active_o(active), .burst_arm_o(arm)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 1'b0; m_k = 0;
    end else if (!en) begin
      m_run = 1'b0; m_k = 0;
    end else if (!m_run) begin
      m_run = 1'b1; m_k = 0;
    end else begin
      m_k = m_k + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_code();
    if (!m_run || m_k >= N*S) return 0;
    return N - m_k / S;
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (!m_run) begin
        chk("R7", "idle prech", int'(prech), 0);
        chk("R7", "idle arm", int'(arm), 0);
        chk("R7", "idle active", int'(active), 0);
        chk("R7", "idle sink_en", int'(sink_en), 0);
        chk("R7", "idle code", int'(code), 0);
      end else begin
        chk("R3", "prech", int'(prech), int'(m_k < P));
        chk("R4", "arm", int'(arm), int'(m_k >= P));
        chk("R5", "code", int'(code), exp_code());
        chk("R6", "active", int'(active), int'(m_k < N*S));
        chk("R6", "sink_en", int'(sink_en), int'(m_k < N*S));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    en = v;
  endtask

  // check the start state one cycle after raising en
  task automatic start_and_check(input string req);
    set_en(1'b1);
    @(negedge clk);
    chk(req, "start prech", int'(prech), 1);
    chk(req, "start code", int'(code), N);
    chk(req, "start active", int'(active), 1);
    chk(req, "start sink_en", int'(sink_en), 1);
    chk(req, "start arm", int'(arm), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1", "reset code", int'(code), 0);
    chk("R1", "reset active", int'(active), 0);
    chk("R1", "reset prech", int'(prech), 0);
    set_en(1'b0);
    rst_ni = 1'b1;
    cyc(6);
    chk("R1", "idle arm", int'(arm), 0);

    // full run, then hold well past the end (R6)
    start_and_check("R2");
    cyc(N*S + 30);
    chk("R6", "hold active", int'(active), 0);
    chk("R4", "hold arm", int'(arm), 1);

    // drop after completion, restart, drop mid ramp (R7, R8)
    set_en(1'b0);
    cyc(4);
    start_and_check("R8");
    cyc(40);
    set_en(1'b0);
    @(negedge clk);
    chk("R7", "mid drop code", int'(code), 0);
    chk("R7", "mid drop arm", int'(arm), 0);
    cyc(3);

    // restart, drop during precharge
    start_and_check("R8");
    cyc(2);
    set_en(1'b0);
    cyc(3);

    // restart, single-cycle low pulse mid ramp, then complete
    start_and_check("R8");
    cyc(25);
    set_en(1'b0);
    set_en(1'b1);
    cyc(N*S + 10);
    chk("R6", "final code", int'(code), 0);

    set_en(1'b0);
    cyc(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule